// File: doc/BRIEF.md
# Pulse Interrupt Aggregator

This block gathers nine one-clock request pulses from the parts of a data-acquisition design and stores each one as a pending bit. The pending bits sit in a source register. An enable register with the same bit layout decides which pending bits may interrupt the host. When a source that is enabled becomes newly pending, the block sends one single-clock pulse to the host bus bridge. A plain register port lets the host read the source register, which clears it, and read or write the enable register.

A source bit is stored whether or not it is enabled. If the same source fires again before the host has read the source register, a sticky bit at the top of the source register records this for debugging. The same read that clears the pending bits also clears that sticky bit.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous reset the pending bits, the overflow bit, the enable register, `reg_rdata` and `irq_o` are all zero.
- R2: A pulse on `req_i[i]` sets pending bit i at the next rising edge, whatever the enable bit i holds. The source bits are: 8 DMA done, 7 DMA error, 6 carrier over-temperature, 5 mezzanine over-temperature, 4 input over-load, 3 ADC trigger, 2 end of acquisition, 1 ID-bus transfer done, 0 ADC configuration transfer done.
- R3: A pulse on a source that is already pending, with no clearing read in the same cycle, sets the overflow bit (source register bit 31). The bit stays set until the source register is read.
- R4: A read with `reg_addr`=0 places {overflow in bit 31, zeros in bits 30..9, pending in bits 8..0} on `reg_rdata` one edge after `reg_rd`. At that same edge all pending bits and the overflow bit are cleared.
- R5: A request pulse that arrives in the same cycle as a clearing read is absent from that read's data. It stays pending, appears in the next read and does not set the overflow bit.
- R6: A write with `reg_addr`=1 stores `reg_wdata[8:0]` as the enable mask. A read with `reg_addr`=1 returns the mask with bits 31..9 as zero. Writes to `reg_addr`=0 and to reserved bits have no effect.
- R7: `irq_o` goes high for exactly one cycle, in the cycle after the edge at which an enabled source becomes newly pending. A source whose enable bit is 0 produces no pulse.
- R8: A different enabled source that becomes pending while others are still pending produces a new pulse. A repeat pulse on a source that is already pending produces no pulse.
- R9: Writing a 1 to the enable bit of a source that is already pending produces one pulse.
- R10: Several sources that fire in the same cycle produce a single pulse and do not set the overflow bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 9 | One-clock request pulses, one per source |
| reg_addr | input | 1 | Register select: 0 = source, 1 = enable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a read of the source register clears it) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | One-clock interrupt pulse to the host bridge |

## Verification
A pending bit and its interrupt pulse both appear at the first rising edge after the request is sampled. Read data and the clearing it causes appear at the first edge after the read strobe. A change of the enable mask takes effect at the write edge, and any pulse it causes is visible in the cycle that follows. The bench drives every input on a falling edge and samples on the next falling edge, which is exactly one register stage later. To check that a pulse lasts one cycle, it samples once more on the following falling edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic {
    SEL_SOURCE = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;

  function automatic logic any_new(input logic [31:0] now_v, input logic [31:0] held_v);
    return |(now_v & ~held_v);
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic               clr,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] pend_nxt,
  output logic [NUM_SRC-1:0] held,
  output logic               ovf_q
);

  logic [NUM_SRC-1:0] repeat_hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign held[i]       = pend_q[i] & ~clr;
    assign repeat_hit[i] = req[i] & held[i];
    assign pend_nxt[i]   = held[i] | req[i];

    always_ff @(posedge clk) begin
      if (rst) pend_q[i] <= 1'b0;
      else     pend_q[i] <= pend_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_q <= 1'b0;
    else     ovf_q <= (ovf_q & ~clr) | (|repeat_hit);
  end

endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int NUM_SRC = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [NUM_SRC-1:0] wbits,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] en_nxt
);

  assign en_nxt = we ? wbits : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nxt;
  end

endmodule

// File: rtl/irq_fire_gen.sv
module irq_fire_gen #(
  parameter int NUM_SRC = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend_nxt,
  input  logic [NUM_SRC-1:0] held,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic [NUM_SRC-1:0] en_nxt,
  output logic               irq_o
);
  import irq_agg_pkg::*;

  logic [31:0] live_v;
  logic [31:0] seen_v;
  logic        fire;

  always_comb begin
    live_v = '0;
    seen_v = '0;
    live_v[NUM_SRC-1:0] = pend_nxt & en_nxt;
    seen_v[NUM_SRC-1:0] = held & en_q;
    fire = any_new(live_v, seen_v);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= fire;
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_SRC = 9,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  import irq_agg_pkg::*;

  localparam int OVF_BIT = DATA_W - 1;

  logic [NUM_SRC-1:0] pend_q, pend_nxt, held;
  logic [NUM_SRC-1:0] en_q, en_nxt;
  logic               ovf_q;
  logic               src_clr, en_we;
  logic [DATA_W-1:0]  src_view, en_view;
  logic               unused_wdata_hi;

  assign src_clr         = reg_rd & (reg_sel_e'(reg_addr) == SEL_SOURCE);
  assign en_we           = reg_wr & (reg_sel_e'(reg_addr) == SEL_ENABLE);
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];

  irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .req(req_i), .clr(src_clr),
    .pend_q(pend_q), .pend_nxt(pend_nxt), .held(held), .ovf_q(ovf_q)
  );

  irq_en_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk(clk), .rst(rst), .we(en_we), .wbits(reg_wdata[NUM_SRC-1:0]),
    .en_q(en_q), .en_nxt(en_nxt)
  );

  irq_fire_gen #(.NUM_SRC(NUM_SRC)) u_fire (
    .clk(clk), .rst(rst), .pend_nxt(pend_nxt), .held(held),
    .en_q(en_q), .en_nxt(en_nxt), .irq_o(irq_o)
  );

  always_comb begin
    src_view = '0;
    src_view[NUM_SRC-1:0] = pend_q;
    src_view[OVF_BIT]     = ovf_q;
    en_view = '0;
    en_view[NUM_SRC-1:0]  = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= (reg_sel_e'(reg_addr) == SEL_SOURCE) ? src_view : en_view;
  end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NUM_SRC = 9,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] req_i,
  input logic               reg_addr,
  input logic               reg_rd,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic               ovf_q
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && reg_rdata == '0));

  assert_latch_R2: assert property (@(posedge clk) disable iff (rst)
    (|req_i) |=> ((pend_q & $past(req_i)) == $past(req_i)));

  assert_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    ((|(req_i & pend_q)) && !(reg_rd && !reg_addr)) |=> ovf_q);

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_addr && req_i == '0) |=> (pend_q == '0 && !ovf_q));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr) |=> (reg_rdata[DATA_W-1:NUM_SRC] == '0));

  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (|(pend_q & en_q)));

endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .irq_o(irq_o), .pend_q(pend_q), .en_q(en_q), .ovf_q(ovf_q)
);

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  req_i = '0;
  logic        reg_addr = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst(rst), .req_i(req_i), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // {enable mask, request pattern, expected pulse}
  localparam logic [18:0] VECS [0:5] = '{
    {9'h1FF, 9'h001, 1'b1},
    {9'h000, 9'h100, 1'b0},
    {9'h010, 9'h008, 1'b0},
    {9'h010, 9'h010, 1'b1},
    {9'h1FF, 9'h0C3, 1'b1},
    {9'h155, 9'h0AA, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_read(input logic a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic do_pulse(input logic [8:0] r, output logic seen);
    @(negedge clk); req_i = r;
    @(negedge clk); req_i = '0; seen = irq_o;
  endtask

  initial begin
    #(8 * 50000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(irq_o == 1'b0, "R1 irq after reset", {31'b0, irq_o}, 32'h0);
    check(reg_rdata == 32'h0, "R1 rdata after reset", reg_rdata, 32'h0);
    do_read(1'b0, d); check(d == 32'h0, "R1 source after reset", d, 32'h0);
    do_read(1'b1, d); check(d == 32'h0, "R1 enable after reset", d, 32'h0);

    // Table walk: R2 latch, R7 pulse and width, R10 simultaneous sources
    for (int k = 0; k < 6; k++) begin
      do_write(1'b1, {23'b0, VECS[k][18:10]});
      do_read(1'b0, d);
      do_pulse(VECS[k][9:1], s);
      check(s == VECS[k][0], "R7 pulse from table", {31'b0, s}, {31'b0, VECS[k][0]});
      @(negedge clk);
      check(irq_o == 1'b0, "R7 pulse width", {31'b0, irq_o}, 32'h0);
      do_read(1'b0, d);
      check(d == {23'b0, VECS[k][9:1]}, "R2/R10 source bits", d, {23'b0, VECS[k][9:1]});
    end

    // R3 overflow and R4 clear
    do_write(1'b1, 32'h0);
    do_pulse(9'h004, s);
    do_pulse(9'h004, s);
    do_read(1'b0, d); check(d == 32'h8000_0004, "R3 overflow set", d, 32'h8000_0004);
    do_read(1'b0, d); check(d == 32'h0, "R4 cleared by read", d, 32'h0);

    // R6 enable mask, reserved bits, source write ignored
    do_write(1'b1, 32'hFFFF_FFFF);
    do_read(1'b1, d); check(d == 32'h0000_01FF, "R6 enable readback", d, 32'h0000_01FF);
    do_write(1'b0, 32'hFFFF_FFFF);
    check(irq_o == 1'b0, "R6 source write no pulse", {31'b0, irq_o}, 32'h0);
    do_read(1'b0, d); check(d == 32'h0, "R6 source write ignored", d, 32'h0);

    // R5 request coinciding with clearing read
    do_pulse(9'h002, s);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 1'b0; req_i = 9'h008;
    @(negedge clk); reg_rd = 1'b0; req_i = '0; d = reg_rdata;
    check(d == 32'h0000_0002, "R5 read excludes new pulse", d, 32'h0000_0002);
    check(irq_o == 1'b1, "R5 pulse for kept request", {31'b0, irq_o}, 32'h1);
    do_read(1'b0, d); check(d == 32'h0000_0008, "R5 kept without overflow", d, 32'h0000_0008);

    // R8 further sources while pending, repeat gives no pulse
    do_pulse(9'h001, s); check(s == 1'b1, "R8 first source", {31'b0, s}, 32'h1);
    do_pulse(9'h010, s); check(s == 1'b1, "R8 second source", {31'b0, s}, 32'h1);
    do_pulse(9'h001, s); check(s == 1'b0, "R8 repeat no pulse", {31'b0, s}, 32'h0);
    do_read(1'b0, d); check(d == 32'h8000_0011, "R8 repeat flagged R3", d, 32'h8000_0011);

    // R9 enabling an already pending source
    do_write(1'b1, 32'h0);
    do_pulse(9'h020, s); check(s == 1'b0, "R9 disabled no pulse", {31'b0, s}, 32'h0);
    do_write(1'b1, 32'h0000_0020);
    check(irq_o == 1'b1, "R9 pulse on enable", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check(irq_o == 1'b0, "R9 pulse width", {31'b0, irq_o}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule